// File: doc/BRIEF.md
# Byte-Stream Command Dispatcher

This block takes a stream of command bytes from a host and reads each one as a one-byte opcode. It collects any operand bytes the opcode needs and then carries out the command. Commands that do no serial shifting are executed here. They set the drive value and direction of a low bank of eight I/O lines and a high bank of four. They sample those lines and return the value. They switch the internal serial-data loopback on or off, load a 16-bit clock divisor, release queued response bytes on demand, and stall until a monitored I/O line reaches a level. Opcodes with bit 7 clear are shift commands, and opcodes 0x90 to 0x93 are bus-cycle commands. The block hands both kinds to an external engine, which then owns the input stream until it signals completion.

Both byte streams use valid/ready. A byte moves only in a cycle where valid and ready are both high. While the output waits on back-pressure, its valid and data hold steady. Response bytes collect in a 16-entry queue and are released to the host only when the queue fills or a send-now command runs. Once released, the queue streams out until it is empty. Deasserting `enable` holds every register in reset. This turns all lines into inputs, empties the queue and drops any command that is partly received.

Top module: `byte_cmd_dispatch`

## Requirements
- R1: With `enable` low, or after reset, `io_oe` is all zero, `out_valid`, `dlg_valid` and `loopback` are 0, and `clk_div` is 0.
- R2: Opcode 0x80 followed by value V and direction D sets `io_oe[7:0]`=D and `io_out[7:0]`=V&D. A line with direction 0 drives 0 on `io_out`.
- R3: Opcode 0x82 followed by V and D sets `io_oe[11:8]`=D[3:0] and `io_out[11:8]`=V[3:0]&D[3:0]. It ignores the upper nibbles and leaves the low bank unchanged.
- R4: Opcode 0x81 queues one response byte equal to `io_in[7:0]`. Opcode 0x83 queues {4'b0000, `io_in[11:8]`}.
- R5: Opcode 0x84 sets `loopback` to 1 and opcode 0x85 clears it.
- R6: Opcode 0x86 followed by byte L and then byte H sets `clk_div`={H,L}. `clk_div` changes only after such a command.
- R7: Queued responses stay hidden (`out_valid`=0) until 16 bytes are queued or opcode 0x87 runs. They then leave in queue order until the queue is empty. While `out_valid` is high and `out_ready` is low, `out_data` is held.
- R8: An opcode with bit 7 set that is not 0x80–0x89 or 0x90–0x93 queues the two bytes 0xFA and then the opcode itself.
- R9: Opcode 0x88 holds `in_ready` low until `io_in[9]` is 1. Opcode 0x89 holds it low until `io_in[9]` is 0.
- R10: Opcodes with bit 7 clear, and opcodes 0x90–0x93, raise `dlg_valid` with `dlg_op` equal to the opcode and `dlg_bus`=`dlg_op[7]`. These hold stable until `dlg_ready`, and `in_ready` is 0 meanwhile. After that, `in_ready` follows `dlg_in_ready` and the block decodes no bytes until `dlg_done`.
- R11: Dropping `enable` discards a partly received command, so the first byte after re-enable is decoded as an opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Block enable; low holds it in reset |
| in_valid | input | 1 | Command byte valid |
| in_data | input | 8 | Command byte |
| in_ready | output | 1 | Command byte accepted when high with in_valid |
| out_valid | output | 1 | Response byte valid |
| out_data | output | 8 | Response byte |
| out_ready | input | 1 | Host takes response byte |
| io_in | input | 12 | Sampled state of the 12 I/O lines |
| io_out | output | 12 | Drive value of the I/O lines |
| io_oe | output | 12 | Output enable per line, 1 = output |
| loopback | output | 1 | Serial data out looped to serial data in |
| clk_div | output | 16 | Serial clock divisor |
| dlg_valid | output | 1 | Handoff request to the external engine |
| dlg_op | output | 8 | Opcode being handed off |
| dlg_bus | output | 1 | 1 = bus-cycle engine, 0 = shift engine |
| dlg_ready | input | 1 | Engine accepts the handoff |
| dlg_in_ready | input | 1 | Engine ready for stream bytes while it owns the stream |
| dlg_done | input | 1 | Engine returns stream ownership |

## Verification
A wrong decoder state shows at the ports within a byte or two. An operand is then taken as an opcode, so an error pair 0xFA appears, or a pin or divisor register changes that should not. A wrong queue pointer or release flag shows up as bytes in the wrong order, as bytes leaking out before a flush, or as a queue that never releases. The scoreboard catches these at the first mismatched byte, and the bench checks that the queue is empty at the end. A stuck wait or handoff state shows at once as `in_ready` low when it should be high.

// File: rtl/cmdd_pkg.sv
package cmdd_pkg;

  typedef enum logic [2:0] {
    ST_OP,
    ST_ARG,
    ST_EXEC,
    ST_ERR2,
    ST_WAIT,
    ST_HAND,
    ST_OWNED
  } cmdd_state_e;

  localparam logic [7:0] OP_SET_LO  = 8'h80;
  localparam logic [7:0] OP_GET_LO  = 8'h81;
  localparam logic [7:0] OP_SET_HI  = 8'h82;
  localparam logic [7:0] OP_GET_HI  = 8'h83;
  localparam logic [7:0] OP_LOOP_ON = 8'h84;
  localparam logic [7:0] OP_LOOP_OFF= 8'h85;
  localparam logic [7:0] OP_DIVISOR = 8'h86;
  localparam logic [7:0] OP_SEND    = 8'h87;
  localparam logic [7:0] OP_WAIT_HI = 8'h88;
  localparam logic [7:0] OP_WAIT_LO = 8'h89;
  localparam logic [7:0] ERR_MARK   = 8'hFA;

  // Commands that take two operand bytes.
  function automatic logic has_operands(logic [7:0] op);
    return (op == OP_SET_LO) || (op == OP_SET_HI) || (op == OP_DIVISOR);
  endfunction

  // Commands executed by an external engine.
  function automatic logic is_handoff(logic [7:0] op);
    return (op[7] == 1'b0) || (op[7:2] == 6'b100100);
  endfunction

endpackage

// File: rtl/cmdd_resp_fifo.sv
module cmdd_resp_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (clr) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  assign head  = mem[rp];
  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));
endmodule

// File: rtl/cmdd_pin_bank.sv
module cmdd_pin_bank #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         wr,
  input  logic [N-1:0] val,
  input  logic [N-1:0] dir,
  output logic [N-1:0] drive,
  output logic [N-1:0] oe
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drive <= '0;
      oe    <= '0;
    end else if (clr) begin
      drive <= '0;
      oe    <= '0;
    end else if (wr) begin
      drive <= val & dir;
      oe    <= dir;
    end
  end
endmodule

// File: rtl/byte_cmd_dispatch.sv
module byte_cmd_dispatch
  import cmdd_pkg::*;
#(
  parameter int LO_W       = 8,
  parameter int HI_W       = 4,
  parameter int RESP_DEPTH = 16,
  parameter int WAIT_LINE  = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic                 in_valid,
  input  logic [7:0]           in_data,
  output logic                 in_ready,
  output logic                 out_valid,
  output logic [7:0]           out_data,
  input  logic                 out_ready,
  input  logic [LO_W+HI_W-1:0] io_in,
  output logic [LO_W+HI_W-1:0] io_out,
  output logic [LO_W+HI_W-1:0] io_oe,
  output logic                 loopback,
  output logic [15:0]          clk_div,
  output logic                 dlg_valid,
  output logic [7:0]           dlg_op,
  output logic                 dlg_bus,
  input  logic                 dlg_ready,
  input  logic                 dlg_in_ready,
  input  logic                 dlg_done
);
  localparam int IO_W = LO_W + HI_W;

  cmdd_state_e state;
  logic [7:0]  op_q, arg0_q, arg1_q;
  logic        arg_idx;
  logic        drain_q;
  logic        clr;
  logic        in_fire;

  logic        push;
  logic [7:0]  push_data;
  logic        pop, f_empty, f_full;
  logic        lo_wr, hi_wr, flush_cmd;
  logic [LO_W-1:0] lo_drive, lo_oe;
  logic [HI_W-1:0] hi_drive, hi_oe;

  assign clr     = !enable;
  assign in_ready = enable && ((state == ST_OP) || (state == ST_ARG) ||
                               ((state == ST_OWNED) && dlg_in_ready));
  assign in_fire = in_valid && in_ready;

  // Actions taken in the execute and error-report states.
  always_comb begin
    push      = 1'b0;
    push_data = '0;
    lo_wr     = 1'b0;
    hi_wr     = 1'b0;
    flush_cmd = 1'b0;
    if (state == ST_EXEC) begin
      case (op_q)
        OP_SET_LO:  lo_wr = 1'b1;
        OP_SET_HI:  hi_wr = 1'b1;
        OP_GET_LO: begin push = !f_full; push_data = 8'(io_in[LO_W-1:0]); end
        OP_GET_HI: begin push = !f_full; push_data = 8'(io_in[IO_W-1:LO_W]); end
        OP_SEND:    flush_cmd = 1'b1;
        OP_LOOP_ON, OP_LOOP_OFF, OP_DIVISOR, OP_WAIT_HI, OP_WAIT_LO: ;
        default: begin push = !f_full; push_data = ERR_MARK; end
      endcase
    end else if (state == ST_ERR2) begin
      push      = !f_full;
      push_data = op_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_OP;
      op_q     <= '0;
      arg0_q   <= '0;
      arg1_q   <= '0;
      arg_idx  <= 1'b0;
      loopback <= 1'b0;
      clk_div  <= '0;
    end else if (clr) begin
      state    <= ST_OP;
      op_q     <= '0;
      arg0_q   <= '0;
      arg1_q   <= '0;
      arg_idx  <= 1'b0;
      loopback <= 1'b0;
      clk_div  <= '0;
    end else begin
      case (state)
        ST_OP: if (in_fire) begin
          op_q    <= in_data;
          arg_idx <= 1'b0;
          if (is_handoff(in_data))        state <= ST_HAND;
          else if (has_operands(in_data)) state <= ST_ARG;
          else                            state <= ST_EXEC;
        end
        ST_ARG: if (in_fire) begin
          if (!arg_idx) begin
            arg0_q  <= in_data;
            arg_idx <= 1'b1;
          end else begin
            arg1_q <= in_data;
            state  <= ST_EXEC;
          end
        end
        ST_EXEC: begin
          case (op_q)
            OP_LOOP_ON:  begin loopback <= 1'b1; state <= ST_OP; end
            OP_LOOP_OFF: begin loopback <= 1'b0; state <= ST_OP; end
            OP_DIVISOR:  begin clk_div <= {arg1_q, arg0_q}; state <= ST_OP; end
            OP_WAIT_HI, OP_WAIT_LO: state <= ST_WAIT;
            OP_GET_LO, OP_GET_HI: if (!f_full) state <= ST_OP;
            OP_SET_LO, OP_SET_HI, OP_SEND: state <= ST_OP;
            default: if (!f_full) state <= ST_ERR2;
          endcase
        end
        ST_ERR2:  if (!f_full) state <= ST_OP;
        ST_WAIT:  if (io_in[WAIT_LINE] == (op_q == OP_WAIT_HI)) state <= ST_OP;
        ST_HAND:  if (dlg_ready) state <= ST_OWNED;
        ST_OWNED: if (dlg_done) state <= ST_OP;
        default:  state <= ST_OP;
      endcase
    end
  end

  // Release control: opens on a full queue or a send-now command, closes once empty.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 drain_q <= 1'b0;
    else if (clr)               drain_q <= 1'b0;
    else if (flush_cmd || f_full) drain_q <= 1'b1;
    else if (f_empty)           drain_q <= 1'b0;
  end

  assign out_valid = drain_q && !f_empty;
  assign pop       = out_valid && out_ready;

  cmdd_resp_fifo #(.W(8), .DEPTH(RESP_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .push(push), .push_data(push_data), .pop(pop),
    .head(out_data), .empty(f_empty), .full(f_full)
  );

  cmdd_pin_bank #(.N(LO_W)) u_lo (
    .clk(clk), .rst_n(rst_n), .clr(clr), .wr(lo_wr),
    .val(arg0_q[LO_W-1:0]), .dir(arg1_q[LO_W-1:0]),
    .drive(lo_drive), .oe(lo_oe)
  );

  cmdd_pin_bank #(.N(HI_W)) u_hi (
    .clk(clk), .rst_n(rst_n), .clr(clr), .wr(hi_wr),
    .val(arg0_q[HI_W-1:0]), .dir(arg1_q[HI_W-1:0]),
    .drive(hi_drive), .oe(hi_oe)
  );

  assign io_out    = {hi_drive, lo_drive};
  assign io_oe     = {hi_oe, lo_oe};
  assign dlg_valid = (state == ST_HAND);
  assign dlg_op    = op_q;
  assign dlg_bus   = op_q[7];
endmodule

// File: rtl/byte_cmd_dispatch_chk.sv
module byte_cmd_dispatch_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        enable,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [7:0]  out_data,
  input logic [11:0] io_oe,
  input logic        dlg_valid,
  input logic        dlg_ready,
  input logic [7:0]  dlg_op,
  input logic [15:0] clk_div
);
  // R1: disabling clears drivers and output handshakes
  a_r1_disable_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (io_oe == '0) && !out_valid && !dlg_valid);

  // R7: response byte held under back-pressure
  a_r7_out_hold: assert property (@(posedge clk) disable iff (!rst_n || !enable)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R10: handoff request held until accepted
  a_r10_hand_hold: assert property (@(posedge clk) disable iff (!rst_n || !enable)
    dlg_valid && !dlg_ready |=> dlg_valid && $stable(dlg_op));

  // R10: no stream byte consumed while a handoff is pending
  a_r10_hand_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    dlg_valid |-> !in_ready);

  // R6: divisor moves only two cycles after a byte was taken, or after a disable
  a_r6_div_source: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(clk_div) |-> $past(in_valid && in_ready, 2) || !$past(enable));
endmodule

bind byte_cmd_dispatch byte_cmd_dispatch_chk u_chk (.*);

// File: tb/byte_cmd_dispatch_test.sv
`timescale 1ns/1ps
module byte_cmd_dispatch_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_ready;
  logic        out_valid;
  logic [7:0]  out_data;
  logic        out_ready = 1'b1;
  logic [11:0] io_in = '0;
  logic [11:0] io_out, io_oe;
  logic        loopback;
  logic [15:0] clk_div;
  logic        dlg_valid, dlg_bus;
  logic [7:0]  dlg_op;
  logic        dlg_ready = 1'b0;
  logic        dlg_in_ready = 1'b0;
  logic        dlg_done = 1'b0;

  int vectors = 0;
  int fails = 0;
  logic [7:0] exp_q[$];

  always #2 clk = ~clk;

  byte_cmd_dispatch uut (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .io_in(io_in), .io_out(io_out), .io_oe(io_oe), .loopback(loopback),
    .clk_div(clk_div), .dlg_valid(dlg_valid), .dlg_op(dlg_op), .dlg_bus(dlg_bus),
    .dlg_ready(dlg_ready), .dlg_in_ready(dlg_in_ready), .dlg_done(dlg_done)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic read_lo(input logic [11:0] pins);
    io_in = pins;
    exp_q.push_back(pins[7:0]);
    send(8'h81);
    settle(2);
  endtask

  // Scoreboard monitor: every released response byte is compared in order.
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      vectors++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R4/R7/R8 unexpected response: got %h expected none", out_data);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        if (out_data !== e) begin
          fails++;
          $display("FAIL R4/R7/R8 response byte: got %h expected %h", out_data, e);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [7:0] held;
    settle(4);
    rst_n = 1'b1;
    settle(2);
    // R1 reset state
    chk("R1 io_oe", io_oe, 0);
    chk("R1 out_valid", out_valid, 0);
    chk("R1 loopback", loopback, 0);
    chk("R1 clk_div", clk_div, 0);
    chk("R1 in_ready", in_ready, 1);

    // R2 low bank
    send(8'h80); send(8'hA5); send(8'h0F); settle(3);
    chk("R2 io_oe", io_oe, 12'h00F);
    chk("R2 io_out", io_out, 12'h005);

    // R3 high bank, upper nibbles ignored, low bank kept
    send(8'h82); send(8'hF9); send(8'hFC); settle(3);
    chk("R3 io_oe", io_oe, 12'hC0F);
    chk("R3 io_out", io_out, 12'h805);

    // R4 pin reads, held until R7 send-now
    io_in = 12'h3C5;
    exp_q.push_back(8'hC5);
    send(8'h81); settle(2);
    exp_q.push_back(8'h03);
    send(8'h83); settle(3);
    chk("R7 held before flush", out_valid, 0);
    send(8'h87); settle(6);
    chk("R7 flush drained", exp_q.size(), 0);

    // R5 loopback
    send(8'h84); settle(3);
    chk("R5 loop on", loopback, 1);
    send(8'h85); settle(3);
    chk("R5 loop off", loopback, 0);

    // R6 divisor
    send(8'h86); send(8'h34); send(8'h12); settle(3);
    chk("R6 clk_div", clk_div, 16'h1234);

    // R8 error reports
    exp_q.push_back(8'hFA); exp_q.push_back(8'h8C);
    send(8'h8C); settle(3);
    exp_q.push_back(8'hFA); exp_q.push_back(8'hA0);
    send(8'hA0); settle(3);
    chk("R8 held before flush", out_valid, 0);
    send(8'h87); settle(8);
    chk("R8 error bytes drained", exp_q.size(), 0);

    // R7 automatic release when full, with back-pressure
    for (int i = 0; i < 15; i++) read_lo(12'h200 | 12'(i * 17));
    chk("R7 not released at 15", out_valid, 0);
    out_ready = 1'b0;
    read_lo(12'h2EE);
    settle(1);
    chk("R7 released when full", out_valid, 1);
    held = out_data;
    settle(3);
    chk("R7 valid held", out_valid, 1);
    chk("R7 data held", out_data, held);
    out_ready = 1'b1;
    settle(20);
    chk("R7 full queue drained", exp_q.size(), 0);
    chk("R7 idle after drain", out_valid, 0);

    // R9 wait for high then low on io_in[9]
    io_in = 12'h000;
    send(8'h88); settle(3);
    chk("R9 stalled wait-high", in_ready, 0);
    io_in = 12'h200; settle(2);
    chk("R9 resumed wait-high", in_ready, 1);
    send(8'h89); settle(3);
    chk("R9 stalled wait-low", in_ready, 0);
    io_in = 12'h000; settle(2);
    chk("R9 resumed wait-low", in_ready, 1);

    // R10 shift handoff
    send(8'h39);
    chk("R10 dlg_valid", dlg_valid, 1);
    chk("R10 dlg_op", dlg_op, 8'h39);
    chk("R10 dlg_bus shift", dlg_bus, 0);
    chk("R10 stream blocked", in_ready, 0);
    settle(2);
    chk("R10 request held", dlg_valid, 1);
    dlg_ready = 1'b1; settle(1); dlg_ready = 1'b0;
    chk("R10 follows engine low", in_ready, 0);
    dlg_in_ready = 1'b1; settle(1);
    chk("R10 follows engine high", in_ready, 1);
    send(8'h84); settle(3);
    chk("R10 owned byte not decoded", loopback, 0);
    dlg_in_ready = 1'b0;
    dlg_done = 1'b1; settle(1); dlg_done = 1'b0;
    settle(1);
    chk("R10 stream returned", in_ready, 1);
    // R10 bus handoff
    send(8'h92);
    chk("R10 dlg_bus bus", dlg_bus, 1);
    chk("R10 dlg_op bus", dlg_op, 8'h92);
    dlg_ready = 1'b1; settle(1); dlg_ready = 1'b0;
    dlg_done = 1'b1; settle(1); dlg_done = 1'b0;
    settle(1);

    // R11 partial command discarded on disable, R1 disabled state
    send(8'h86); send(8'h11);
    enable = 1'b0; settle(2);
    chk("R1 disabled io_oe", io_oe, 0);
    chk("R1 disabled in_ready", in_ready, 0);
    enable = 1'b1; settle(1);
    chk("R1 clk_div after disable", clk_div, 0);
    io_in = 12'h07E;
    exp_q.push_back(8'h7E);
    send(8'h81); settle(2);
    send(8'h87); settle(5);
    chk("R11 next byte is opcode", exp_q.size(), 0);
    chk("R11 divisor untouched", clk_div, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule